// File: doc/BRIEF.md
# SMBus Host Controller

This block is a bus master for the System Management Bus. A processor sets it up through a small byte-wide register file. It loads a target byte, which holds the seven-bit device address and a direction bit. It also loads a command byte and, for writes, a payload byte. It then launches a transfer by writing a protocol code. Four transfers are supported: send a single byte, receive a single byte, write a byte to a command location, and read a byte from a command location.

The block drives the open-drain clock and data lines. It generates start, repeated-start and stop conditions. It checks the target's acknowledge after every byte it sends and gives a not-acknowledge after the one byte it receives. The bus clock comes from a divider: one bus bit lasts four quarter-periods of `QTR_CYCLES` system clocks each. With the default setting and a 250 MHz system clock, the bus runs at 100 kHz.

Software polls the status register. It reads zero for as long as a transfer is running. When the transfer ends, the status reports the outcome, and any byte received is placed in the first data register.

Top module: `smb_host`

## Requirements
- R1: After reset every register reads 0x00 and both bus lines are released (neither drive output asserted).
- R2: The register offsets are: 0 protocol (read back as last accepted), 1 status (read-only, writes ignored), 2 target, 3 command, 4 data0 and 5 data1. Offsets 2 to 5 read back what was written.
- R3: Code 0x04 produces start, target byte, data0 byte, stop. The target byte is sent exactly as written, and the target must acknowledge each byte.
- R4: Code 0x05 produces start and the target byte, then reads 8 bits MSB first into data0. The master releases SDA in the ninth slot (not-acknowledge) and then gives stop.
- R5: Code 0x06 produces start, target byte, command byte, data0 byte, stop.
- R6: Code 0x07 produces start, the target with bit 0 forced to 0, and the command byte. It then gives a repeated start and the target with bit 0 forced to 1, reads one byte into data0 with not-acknowledge, and gives stop.
- R7: An accepted write to offset 0 clears the status to 0x00, and the status stays 0x00 until the transfer ends.
- R8: A transfer in which every sent byte is acknowledged ends with status 0x81 (bit 7 success, bit 0 done).
- R9: A not-acknowledge on any sent byte skips the remaining bytes, gives stop at once and ends with status 0x11 (bit 4 not-acknowledge, bit 0 done).
- R10: A code outside 0x04..0x07 causes no bus activity, and the status becomes 0x05 (bit 2 bad code, bit 0 done) two clocks after the write.
- R11: A write to offset 0 while a transfer runs is ignored. The protocol readback and the transfer in progress are both unchanged.
- R12: SDA changes while SCL is high only to form a start or a stop. Consecutive SCL rising edges within a byte are 4*QTR_CYCLES clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset for read and write |
| regWr | input | 1 | Write strobe, one cycle per byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | Pull SCL low when 1, release when 0 |
| sdaDriveLow | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
A behavioural target on the wires decodes every start, stop, byte and acknowledge slot into an event list, which is compared with the list predicted for each of the four protocol codes. Several different payloads are sent and returned: 0x3C, 0x96, 0x5A and 0xC3. Together they separate bit-order and polarity faults from faults in framing or sequencing. Two not-acknowledge runs, one on the address and one on the command byte, show whether the sequencer stops at the right byte. A bad code and a launch issued while busy show whether the launch is gated.

// File: rtl/smb_host_pkg.sv
`timescale 1ns/1ps
package smb_host_pkg;

  localparam logic [2:0] A_PROTO = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_TGT   = 3'd2;
  localparam logic [2:0] A_CMD   = 3'd3;
  localparam logic [2:0] A_D0    = 3'd4;
  localparam logic [2:0] A_D1    = 3'd5;

  localparam logic [7:0] ST_DONE = 8'h01;
  localparam logic [7:0] ST_BADP = 8'h04;
  localparam logic [7:0] ST_NACK = 8'h10;
  localparam logic [7:0] ST_OK   = 8'h80;

  typedef enum logic [3:0] {
    SG_START, SG_TX_ADDR, SG_TX_ADDRW, SG_TX_ADDRR,
    SG_TX_CMD, SG_TX_DATA, SG_RX_DATA, SG_STOP, SG_END
  } segT;

  typedef enum logic [2:0] {
    LD_NONE, LD_ADDR, LD_ADDRW, LD_ADDRR, LD_CMD, LD_DATA
  } ldSelT;

  typedef struct packed {
    logic       divRun;
    ldSelT      ldSel;
    logic       shiftOut;
    logic       shiftIn;
    logic       rxBit;
    logic       storeRx;
    logic       finish;
    logic [7:0] finStatus;
  } strobeT;

  // Segment list per protocol (low two code bits) and step index.
  function automatic segT segAt(input logic [1:0] p, input logic [2:0] idx);
    segT s;
    s = SG_STOP;
    if (idx == 3'd0) s = SG_START;
    else case (p)
      2'd0: if (idx == 3'd1) s = SG_TX_ADDR; else if (idx == 3'd2) s = SG_TX_DATA;
      2'd1: if (idx == 3'd1) s = SG_TX_ADDR; else if (idx == 3'd2) s = SG_RX_DATA;
      2'd2: case (idx)
              3'd1: s = SG_TX_ADDR;
              3'd2: s = SG_TX_CMD;
              3'd3: s = SG_TX_DATA;
              default: s = SG_STOP;
            endcase
      default: case (idx)
              3'd1: s = SG_TX_ADDRW;
              3'd2: s = SG_TX_CMD;
              3'd3: s = SG_START;
              3'd4: s = SG_TX_ADDRR;
              3'd5: s = SG_RX_DATA;
              default: s = SG_STOP;
            endcase
    endcase
    return s;
  endfunction

  function automatic ldSelT ldFor(input segT s);
    case (s)
      SG_TX_ADDR:  return LD_ADDR;
      SG_TX_ADDRW: return LD_ADDRW;
      SG_TX_ADDRR: return LD_ADDRR;
      SG_TX_CMD:   return LD_CMD;
      SG_TX_DATA:  return LD_DATA;
      default:     return LD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/smb_host_dp.sv
`timescale 1ns/1ps
module smb_host_dp
  import smb_host_pkg::*;
#(
  parameter int QTR_CYCLES = 625
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       busy,
  input  strobeT     st,
  output logic       launch,
  output logic [7:0] launchCode,
  output logic       tick,
  output logic       txBit
);
  localparam int CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYCLES - 1);

  logic [7:0] protoQ, statusQ, tgtQ, cmdQ, d0Q, d1Q, shiftQ;
  logic [CNT_W-1:0] divCnt;

  assign launch     = regWr && (regAddr == A_PROTO) && !busy;
  assign launchCode = regWrData;
  assign tick       = st.divRun && (divCnt == CNT_LAST);
  assign txBit      = shiftQ[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoQ <= '0; statusQ <= '0; tgtQ <= '0; cmdQ <= '0;
      d0Q <= '0; d1Q <= '0; shiftQ <= '0; divCnt <= '0;
    end else begin
      if (launch) begin
        protoQ  <= regWrData;
        statusQ <= '0;
      end else if (st.finish) begin
        statusQ <= st.finStatus;
      end
      if (regWr && regAddr == A_TGT) tgtQ <= regWrData;
      if (regWr && regAddr == A_CMD) cmdQ <= regWrData;
      if (regWr && regAddr == A_D1)  d1Q  <= regWrData;
      if (st.storeRx) d0Q <= shiftQ;
      else if (regWr && regAddr == A_D0) d0Q <= regWrData;

      case (st.ldSel)
        LD_ADDR:  shiftQ <= tgtQ;
        LD_ADDRW: shiftQ <= {tgtQ[7:1], 1'b0};
        LD_ADDRR: shiftQ <= {tgtQ[7:1], 1'b1};
        LD_CMD:   shiftQ <= cmdQ;
        LD_DATA:  shiftQ <= d0Q;
        default: begin
          if (st.shiftOut)     shiftQ <= {shiftQ[6:0], 1'b0};
          else if (st.shiftIn) shiftQ <= {shiftQ[6:0], st.rxBit};
        end
      endcase

      if (!st.divRun || divCnt == CNT_LAST) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      A_PROTO: regRdData = protoQ;
      A_STAT:  regRdData = statusQ;
      A_TGT:   regRdData = tgtQ;
      A_CMD:   regRdData = cmdQ;
      A_D0:    regRdData = d0Q;
      A_D1:    regRdData = d1Q;
      default: regRdData = 8'h00;
    endcase
  end

  // R7: status stays zero for the whole transfer
  p_busy_status_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (statusQ == 8'h00));
  // R8: the end of a transfer always leaves the done bit
  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> statusQ[0]);
  // R11: protocol writes while busy leave the register untouched
  p_ignore_busy_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_PROTO && busy) |=> $stable(protoQ));
  // R3: at most one shift-register or status operation per cycle
  p_single_op_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldSel != LD_NONE, st.shiftOut, st.shiftIn, st.storeRx, st.finish}));
endmodule

// File: rtl/smb_host_ctl.sv
`timescale 1ns/1ps
module smb_host_ctl
  import smb_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       launch,
  input  logic [7:0] launchCode,
  input  logic       tick,
  input  logic       txBit,
  input  logic       sdaIn,
  output logic       busy,
  output strobeT     st,
  output logic       sclLow,
  output logic       sdaLow
);
  segT        seg, nextSeg;
  logic [2:0] segIdx;
  logic [1:0] protoSel, qtr;
  logic [3:0] bitCnt;
  logic       nackSeen, badCode, sdaHeld;
  logic       bitEnd, isTx, isRx, codeBad;

  assign nextSeg = segAt(protoSel, segIdx + 3'd1);
  assign bitEnd  = busy && tick && (qtr == 2'd3);
  assign isTx    = seg inside {SG_TX_ADDR, SG_TX_ADDRW, SG_TX_ADDRR, SG_TX_CMD, SG_TX_DATA};
  assign isRx    = (seg == SG_RX_DATA);
  assign codeBad = (launchCode[7:2] != 6'b000001);

  always_comb begin
    st = '0;
    st.ldSel  = LD_NONE;
    st.rxBit  = sdaIn;
    st.divRun = busy && (seg != SG_END);
    if (busy && seg == SG_END) begin
      st.finish    = 1'b1;
      st.finStatus = ST_DONE | (badCode ? ST_BADP : (nackSeen ? ST_NACK : ST_OK));
    end else if (bitEnd) begin
      if (seg == SG_START) st.ldSel = ldFor(nextSeg);
      else if (isTx) begin
        if (bitCnt < 4'd8) st.shiftOut = 1'b1;
        else if (!sdaIn) st.ldSel = ldFor(nextSeg);
      end else if (isRx) begin
        if (bitCnt < 4'd8) st.shiftIn = 1'b1;
        else st.storeRx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; seg <= SG_START; segIdx <= '0; protoSel <= '0;
      qtr <= '0; bitCnt <= '0; nackSeen <= 1'b0; badCode <= 1'b0; sdaHeld <= 1'b0;
    end else begin
      sdaHeld <= sdaLow;
      if (launch) begin
        busy     <= 1'b1;
        protoSel <= launchCode[1:0];
        segIdx   <= '0;
        bitCnt   <= '0;
        qtr      <= 2'd2;
        nackSeen <= 1'b0;
        badCode  <= codeBad;
        seg      <= codeBad ? SG_END : SG_START;
      end else if (busy) begin
        if (seg == SG_END) begin
          busy <= 1'b0;
        end else if (tick) begin
          qtr <= qtr + 2'd1;
          if (qtr == 2'd3) begin
            if (seg == SG_STOP) seg <= SG_END;
            else if (seg == SG_START) begin
              seg <= nextSeg; segIdx <= segIdx + 3'd1; bitCnt <= '0;
            end else if (bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (isTx && sdaIn) begin
                nackSeen <= 1'b1; seg <= SG_STOP;
              end else begin
                seg <= nextSeg; segIdx <= segIdx + 3'd1;
              end
            end else bitCnt <= bitCnt + 4'd1;
          end
        end
      end
    end
  end

  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    if (busy && seg != SG_END) begin
      sclLow = (qtr < 2'd2);
      if (qtr == 2'd0) sdaLow = sdaHeld;
      else case (seg)
        SG_START: sdaLow = (qtr == 2'd3);
        SG_STOP:  sdaLow = (qtr != 2'd3);
        SG_RX_DATA: sdaLow = 1'b0;
        default:  sdaLow = (bitCnt < 4'd8) && !txBit;
      endcase
    end
  end

  // R12: SDA moves under a high SCL only for start and stop
  p_sda_change_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLow && !$past(sclLow) && (sdaLow != $past(sdaLow)))
      |-> ((seg == SG_START || seg == SG_STOP) && qtr == 2'd3));
  // R9: a not-acknowledge on a sent byte leads straight to stop
  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitEnd && isTx && bitCnt == 4'd8 && sdaIn) |=> (seg == SG_STOP));
  // R10: a bad code finishes without touching the bus
  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (launch && codeBad) |=> (busy && seg == SG_END && !sclLow && !sdaLow));
endmodule

// File: rtl/smb_host.sv
`timescale 1ns/1ps
module smb_host
  import smb_host_pkg::*;
#(
  parameter int QTR_CYCLES = 625
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);
  strobeT     st;
  logic       busy, launch, tick, txBit;
  logic [7:0] launchCode;

  smb_host_dp #(.QTR_CYCLES(QTR_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .st(st),
    .launch(launch), .launchCode(launchCode), .tick(tick), .txBit(txBit)
  );

  smb_host_ctl uCtl (
    .clk(clk), .rstN(rstN), .launch(launch), .launchCode(launchCode),
    .tick(tick), .txBit(txBit), .sdaIn(sdaIn), .busy(busy), .st(st),
    .sclLow(sclDriveLow), .sdaLow(sdaDriveLow)
  );
endmodule

// File: tb/sim_smb_host.sv
`timescale 1ns/1ps
module sim_smb_host;
  localparam int QTR = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam int EV_START = 256, EV_STOP = 257, EV_MACK = 300;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic sdaIn, sclDriveLow, sdaDriveLow;
  logic slvDrv = 1'b0;

  always #2 clk = ~clk;

  assign sdaIn = !(sdaDriveLow || slvDrv);

  smb_host #(.QTR_CYCLES(QTR)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  int total = 0, bad = 0, cyc = 0;
  int events[$];
  int expQ[$];

  // behavioural target on the wires
  logic pScl = 1'b1, pSda = 1'b1, readMode = 1'b0, readDone = 1'b0;
  logic [7:0] sh = '0, readVal = '0;
  int inFrame = 0, bitCnt = 0, byteIdx = 0, nackIdx = -1;
  int lastRise = -1, risePeriod = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic scl, sda;
    scl = !sclDriveLow;
    sda = !(sdaDriveLow || slvDrv);
    if (rstN) begin
      if (pScl && scl && pSda && !sda) begin
        events.push_back(EV_START);
        inFrame = 1; bitCnt = 0; byteIdx = 0; readMode = 1'b0; readDone = 1'b0; slvDrv = 1'b0;
      end else if (pScl && scl && !pSda && sda) begin
        events.push_back(EV_STOP);
        inFrame = 0; slvDrv = 1'b0;
      end else if (!pScl && scl && inFrame != 0) begin
        if (lastRise >= 0 && bitCnt > 0 && bitCnt < 8) risePeriod = cyc - lastRise;
        lastRise = cyc;
        if (bitCnt < 8) sh = {sh[6:0], sda};
        else if (readMode && byteIdx > 0) begin
          events.push_back(EV_MACK + int'(sda));
          if (sda) readDone = 1'b1;
        end
        bitCnt++;
      end else if (pScl && !scl && inFrame != 0) begin
        if (bitCnt == 8) begin
          if (!(readMode && byteIdx > 0)) begin
            events.push_back(int'(sh));
            if (byteIdx == 0) begin
              readMode = sh[0];
              slvDrv = (sh[7:1] == DEV);
            end else slvDrv = (byteIdx != nackIdx);
          end else slvDrv = 1'b0;
        end else if (bitCnt >= 9) begin
          bitCnt = 0;
          byteIdx++;
          slvDrv = (readMode && byteIdx > 0 && !readDone) ? !readVal[7] : 1'b0;
        end else if (bitCnt >= 1 && readMode && byteIdx > 0 && !readDone) begin
          slvDrv = !readVal[7 - bitCnt];
        end
      end
    end
    pScl = scl;
    pSda = sda;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 5000 && st == 8'h00; i++) begin
      @(negedge clk);
      rdReg(3'd1, st);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cmpEvents(input string req);
    check({req, " event count"}, events.size(), expQ.size());
    if (events.size() == expQ.size())
      foreach (expQ[i]) check({req, " event"}, events[i], expQ[i]);
  endtask

  task automatic launchXfer(input logic [7:0] code);
    logic [7:0] s;
    events.delete();
    wrReg(3'd0, code);
    rdReg(3'd1, s);
    check("R7 status clear at launch", s, 8'h00);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rdReg(3'(a), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 scl released", sclDriveLow, 0);
    check("R1 sda released", sdaDriveLow, 0);

    // R2: register map
    wrReg(3'd2, 8'h11); wrReg(3'd3, 8'h22); wrReg(3'd4, 8'h33); wrReg(3'd5, 8'h44);
    wrReg(3'd1, 8'hFF);
    rdReg(3'd2, v); check("R2 target readback", v, 8'h11);
    rdReg(3'd3, v); check("R2 command readback", v, 8'h22);
    rdReg(3'd4, v); check("R2 data0 readback", v, 8'h33);
    rdReg(3'd5, v); check("R2 data1 readback", v, 8'h44);
    rdReg(3'd1, v); check("R2 status read-only", v, 8'h00);

    // R3 send byte, with R11 busy write in the middle
    wrReg(3'd2, 8'hA0); wrReg(3'd4, 8'h3C);
    launchXfer(8'h04);
    wrReg(3'd0, 8'h07);
    rdReg(3'd0, v); check("R11 protocol unchanged while busy", v, 8'h04);
    rdReg(3'd1, v); check("R7 status zero while busy", v, 8'h00);
    waitDone(s);
    check("R8 send status", s, 8'h81);
    expQ = '{EV_START, 'hA0, 'h3C, EV_STOP};
    cmpEvents("R3 R11 send byte");
    check("R12 scl rise spacing", risePeriod, 4 * QTR);

    // R4 receive byte
    readVal = 8'h96;
    wrReg(3'd2, 8'hA1);
    launchXfer(8'h05);
    waitDone(s);
    check("R8 receive status", s, 8'h81);
    rdReg(3'd4, v); check("R4 received data0", v, 8'h96);
    expQ = '{EV_START, 'hA1, EV_MACK + 1, EV_STOP};
    cmpEvents("R4 receive byte");

    // R5 write byte data
    wrReg(3'd2, 8'hA0); wrReg(3'd3, 8'h12); wrReg(3'd4, 8'h5A);
    launchXfer(8'h06);
    waitDone(s);
    check("R8 write-data status", s, 8'h81);
    expQ = '{EV_START, 'hA0, 'h12, 'h5A, EV_STOP};
    cmpEvents("R5 write byte data");

    // R6 read byte data, target bit0 preset to 1 to show forcing
    readVal = 8'hC3;
    wrReg(3'd2, 8'hA1); wrReg(3'd3, 8'h34);
    launchXfer(8'h07);
    waitDone(s);
    check("R8 read-data status", s, 8'h81);
    rdReg(3'd4, v); check("R6 read data0", v, 8'hC3);
    expQ = '{EV_START, 'hA0, 'h34, EV_START, 'hA1, EV_MACK + 1, EV_STOP};
    cmpEvents("R6 read byte data");

    // R9 address not acknowledged
    wrReg(3'd2, 8'hB0); wrReg(3'd4, 8'h77);
    launchXfer(8'h06);
    waitDone(s);
    check("R9 address nack status", s, 8'h11);
    expQ = '{EV_START, 'hB0, EV_STOP};
    cmpEvents("R9 address nack");

    // R9 command byte not acknowledged
    nackIdx = 1;
    wrReg(3'd2, 8'hA0); wrReg(3'd3, 8'h12);
    launchXfer(8'h06);
    waitDone(s);
    check("R9 command nack status", s, 8'h11);
    expQ = '{EV_START, 'hA0, 'h12, EV_STOP};
    cmpEvents("R9 command nack");
    nackIdx = -1;

    // R10 unknown code
    launchXfer(8'h09);
    @(negedge clk);
    rdReg(3'd1, v); check("R10 bad code status", v, 8'h05);
    check("R10 scl idle", sclDriveLow, 0);
    check("R10 sda idle", sdaDriveLow, 0);
    repeat (8 * QTR) @(negedge clk);
    check("R10 no bus events", events.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule